// File: doc/BRIEF.md
# Three-Operand Integer Adder

A registered execution unit that sums three 32-bit integer operands under the control of a 64-bit instruction word. Every operand may first be narrowed to one of its 16-bit halves (zero-extended) and may then be negated in two's complement. The unit adds the first two operands, optionally folds in an incoming carry flag, optionally shifts that partial sum by 16 bits in either direction, and then adds the third operand.

When the instruction asks for it, the unit also produces zero, sign, carry and overflow flags. Here the overflow flag also catches an unsigned wrap of the first addition. On a right shift the partial sum keeps the carry-out of the first adder, so it behaves as a 33-bit value. Control combinations with no defined meaning raise an error strobe, and in that case nothing is written.

The surrounding pipeline fetches the operands and consumes the results. A single start strobe launches one operation, and the outcome appears on the following clock.

Top module: `tri_add_unit`

## Requirements
- R1: While rst_ni is low, every output is zero: result, destination, the four flags, valid_o, flag_we_o and err_o.
- R2: Each operand passes through a 2-bit half selector. Code 0 passes the whole word. Code 1 keeps bits 15:0 zero-extended. Code 2 keeps bits 31:16 zero-extended. The selector for A is instr_i[36:35], for B is instr_i[34:33] and for C is instr_i[32:31].
- R3: instr_i[51], instr_i[50] and instr_i[49] negate operands A, B and C respectively (two's complement). Negation is applied after half selection.
- R4: The result is shift(A + B + (instr_i[48] & carry_i)) + C, modulo 2^32. It appears on result_o one clock after start_i, together with a one-cycle valid_o pulse and dest_o = instr_i[7:0].
- R5: The shift field instr_i[38:37] selects the shift. Code 0 applies no shift. Code 1 is a logical right shift by 16. Code 2 is a logical left shift by 16.
- R6: Under a right shift, a carry-out of the first addition is kept. The shifted value equals the 33-bit first sum shifted right by 16, which amounts to adding 0x10000 when that carry is set.
- R7: When instr_i[47] is set, flag_we_o pulses with valid_o and the flags are written. zero_o is set when the result is zero. sign_o is result bit 31. carry_o is the carry-out of the final addition. Without a flag write, all four flags hold their values.
- R8: ovf_o is the signed overflow of the final addition ORed with an unsigned wrap of the first addition. A wrap is detected when that first sum is unsigned-less-than operand A.
- R9: Some operations are unsupported: instr_i[48] together with a right shift, instr_i[48] together with instr_i[47], or code 3 in any half selector or in the shift field. Such an operation gives a one-cycle err_o pulse with valid_o and flag_we_o low, and leaves the result, destination and flags unchanged.
- R10: In a cycle after which start_i was low, valid_o, flag_we_o and err_o are low, and result_o and dest_o hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launch one operation |
| op_a_i | input | 32 | Operand A |
| op_b_i | input | 32 | Operand B |
| op_c_i | input | 32 | Operand C |
| instr_i | input | 64 | Instruction word carrying the control fields |
| carry_i | input | 1 | Incoming carry flag |
| result_o | output | 32 | Sum |
| dest_o | output | 8 | Destination register index |
| valid_o | output | 1 | Result strobe |
| zero_o | output | 1 | Zero flag |
| sign_o | output | 1 | Sign flag |
| carry_o | output | 1 | Carry flag |
| ovf_o | output | 1 | Overflow flag |
| flag_we_o | output | 1 | Flag write strobe |
| err_o | output | 1 | Unsupported-combination strobe |

## Verification
Directed patterns isolate single features. One is a first sum that carries out under a right shift, which separates 33-bit behaviour from a plain 32-bit shift. Others are a high-half selection, a negated unit operand, and a carry-in applied with the flag both set and clear. Two further cases tell the two overflow sources apart: a first-stage wrap that leaves a zero result with no signed overflow, and a signed overflow in the final add with no wrap. Random operations mix every field, including occasional reserved codes and illegal pairings. This shows that error cases write nothing and that the flags hold between flag writes.

// File: rtl/tri_add_pkg.sv
package tri_add_pkg;
  localparam int unsigned INSTR_W    = 64;
  localparam int unsigned DEST_W     = 8;
  localparam int unsigned POS_HALF_C = 31;
  localparam int unsigned POS_HALF_B = 33;
  localparam int unsigned POS_HALF_A = 35;
  localparam int unsigned POS_SHIFT  = 37;
  localparam int unsigned POS_CC     = 47;
  localparam int unsigned POS_X      = 48;
  localparam int unsigned POS_NEG_C  = 49;
  localparam int unsigned POS_NEG_B  = 50;
  localparam int unsigned POS_NEG_A  = 51;

  typedef enum logic [1:0] {
    HALF_ALL = 2'd0,
    HALF_LO  = 2'd1,
    HALF_HI  = 2'd2,
    HALF_RSV = 2'd3
  } half_sel_e;

  typedef enum logic [1:0] {
    SH_NONE  = 2'd0,
    SH_RIGHT = 2'd1,
    SH_LEFT  = 2'd2,
    SH_RSV   = 2'd3
  } shift_e;

  // index 0 = A, 1 = B, 2 = C
  typedef struct packed {
    logic [2:0][1:0]   half;
    logic [2:0]        neg;
    logic [1:0]        shift;
    logic              ext;
    logic              cc;
    logic [DEST_W-1:0] dest;
  } ctrl_t;
endpackage

// File: rtl/tri_add_decode.sv
module tri_add_decode
  import tri_add_pkg::*;
(
  input  logic [INSTR_W-1:0] instr_i,
  output ctrl_t              ctrl_o,
  output logic               bad_o
);
  logic unused_bits;
  assign unused_bits = ^{instr_i[INSTR_W-1:POS_NEG_A+1],
                         instr_i[POS_CC-1:POS_SHIFT+2],
                         instr_i[POS_HALF_C-1:DEST_W]};

  always_comb begin
    ctrl_o.half[0] = instr_i[POS_HALF_A +: 2];
    ctrl_o.half[1] = instr_i[POS_HALF_B +: 2];
    ctrl_o.half[2] = instr_i[POS_HALF_C +: 2];
    ctrl_o.neg     = {instr_i[POS_NEG_C], instr_i[POS_NEG_B], instr_i[POS_NEG_A]};
    ctrl_o.shift   = instr_i[POS_SHIFT +: 2];
    ctrl_o.ext     = instr_i[POS_X];
    ctrl_o.cc      = instr_i[POS_CC];
    ctrl_o.dest    = instr_i[DEST_W-1:0];
  end

  logic rsv_code;
  always_comb begin
    rsv_code = (ctrl_o.shift == SH_RSV);
    for (int i = 0; i < 3; i++) begin
      if (ctrl_o.half[i] == HALF_RSV) rsv_code = 1'b1;
    end
  end

  assign bad_o = rsv_code
               | (ctrl_o.ext & (ctrl_o.shift == SH_RIGHT))
               | (ctrl_o.ext & ctrl_o.cc);
endmodule

// File: rtl/tri_add_operand.sv
module tri_add_operand
  import tri_add_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] val_i,
  input  logic [1:0]   half_i,
  input  logic         neg_i,
  output logic [W-1:0] val_o
);
  localparam int unsigned HW = W / 2;

  logic [W-1:0] sel;
  always_comb begin
    case (half_i)
      HALF_LO: sel = {{(W-HW){1'b0}}, val_i[HW-1:0]};
      HALF_HI: sel = {{HW{1'b0}}, val_i[W-1:HW]};
      default: sel = val_i;
    endcase
  end

  assign val_o = neg_i ? (~sel + {{(W-1){1'b0}}, 1'b1}) : sel;
endmodule

// File: rtl/tri_add_core.sv
module tri_add_core
  import tri_add_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] c_i,
  input  logic         cin_i,
  input  logic [1:0]   shift_i,
  output logic [W-1:0] sum_o,
  output logic         zero_o,
  output logic         sign_o,
  output logic         carry_o,
  output logic         ovf_o
);
  localparam int unsigned HW = W / 2;

  logic [W:0]   sum1;
  logic [W-1:0] lhs1, lhs2;
  logic [W:0]   sum2;

  assign sum1 = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i};
  assign lhs1 = sum1[W-1:0];

  // right shift keeps the first carry as bit W
  always_comb begin
    case (shift_i)
      SH_RIGHT: lhs2 = {{(HW-1){1'b0}}, sum1[W:HW]};
      SH_LEFT:  lhs2 = {lhs1[W-HW-1:0], {HW{1'b0}}};
      default:  lhs2 = lhs1;
    endcase
  end

  assign sum2    = {1'b0, lhs2} + {1'b0, c_i};
  assign sum_o   = sum2[W-1:0];
  assign zero_o  = (sum2[W-1:0] == '0);
  assign sign_o  = sum2[W-1];
  assign carry_o = sum2[W];
  assign ovf_o   = ((lhs2[W-1] == c_i[W-1]) && (sum2[W-1] != lhs2[W-1]))
                 | (lhs1 < a_i);
endmodule

// File: rtl/tri_add_unit.sv
module tri_add_unit
  import tri_add_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [W-1:0]        op_a_i,
  input  logic [W-1:0]        op_b_i,
  input  logic [W-1:0]        op_c_i,
  input  logic [INSTR_W-1:0]  instr_i,
  input  logic                carry_i,
  output logic [W-1:0]        result_o,
  output logic [DEST_W-1:0]   dest_o,
  output logic                valid_o,
  output logic                zero_o,
  output logic                sign_o,
  output logic                carry_o,
  output logic                ovf_o,
  output logic                flag_we_o,
  output logic                err_o
);
  ctrl_t ctrl;
  logic  bad;

  tri_add_decode u_dec (
    .instr_i (instr_i),
    .ctrl_o  (ctrl),
    .bad_o   (bad)
  );

  logic [2:0][W-1:0] raw, prep;
  assign raw[0] = op_a_i;
  assign raw[1] = op_b_i;
  assign raw[2] = op_c_i;

  for (genvar i = 0; i < 3; i++) begin : g_op
    tri_add_operand #(.W(W)) u_op (
      .val_i  (raw[i]),
      .half_i (ctrl.half[i]),
      .neg_i  (ctrl.neg[i]),
      .val_o  (prep[i])
    );
  end

  logic [W-1:0] sum;
  logic         z, s, cy, ov;

  tri_add_core #(.W(W)) u_core (
    .a_i     (prep[0]),
    .b_i     (prep[1]),
    .c_i     (prep[2]),
    .cin_i   (ctrl.ext & carry_i),
    .shift_i (ctrl.shift),
    .sum_o   (sum),
    .zero_o  (z),
    .sign_o  (s),
    .carry_o (cy),
    .ovf_o   (ov)
  );

  logic go, go_flags;
  assign go       = start_i & ~bad;
  assign go_flags = go & ctrl.cc;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      flag_we_o <= 1'b0;
      err_o     <= 1'b0;
    end else begin
      valid_o   <= go;
      flag_we_o <= go_flags;
      err_o     <= start_i & bad;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o <= '0;
      dest_o   <= '0;
    end else if (go) begin
      result_o <= sum;
      dest_o   <= ctrl.dest;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      zero_o  <= 1'b0;
      sign_o  <= 1'b0;
      carry_o <= 1'b0;
      ovf_o   <= 1'b0;
    end else if (go_flags) begin
      zero_o  <= z;
      sign_o  <= s;
      carry_o <= cy;
      ovf_o   <= ov;
    end
  end
endmodule

// File: rtl/tri_add_chk.sv
module tri_add_chk #(
  parameter int unsigned W = 32
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         start_i,
  input logic [63:0]  instr_i,
  input logic [W-1:0] result_o,
  input logic [7:0]   dest_o,
  input logic         valid_o,
  input logic         zero_o,
  input logic         sign_o,
  input logic         carry_o,
  input logic         ovf_o,
  input logic         flag_we_o,
  input logic         err_o
);
  always_comb begin
    if (!rst_ni) begin
      assert_reset_R1: assert (!valid_o && !err_o && !flag_we_o && result_o == '0);
    end
  end

  assert_strobe_src_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o || err_o || flag_we_o) |-> $past(start_i));

  assert_dest_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> dest_o == $past(instr_i[7:0]));

  assert_fwe_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_we_o |-> (valid_o && $past(instr_i[47])));

  assert_zs_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_we_o |-> ((zero_o == (result_o == '0)) && (sign_o == result_o[W-1])));

  assert_flag_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flag_we_o |-> $stable({zero_o, sign_o, carry_o, ovf_o}));

  assert_err_excl_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (!valid_o && !flag_we_o));

  assert_err_xcc_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(start_i) && $past(instr_i[48]) && $past(instr_i[47])) |-> err_o);

  assert_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> ($stable(result_o) && $stable(dest_o)));
endmodule

bind tri_add_unit tri_add_chk #(.W(W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .instr_i   (instr_i),
  .result_o  (result_o),
  .dest_o    (dest_o),
  .valid_o   (valid_o),
  .zero_o    (zero_o),
  .sign_o    (sign_o),
  .carry_o   (carry_o),
  .ovf_o     (ovf_o),
  .flag_we_o (flag_we_o),
  .err_o     (err_o)
);

// File: tb/tri_add_unit_test.sv
module tri_add_unit_test;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] op_a_i = '0, op_b_i = '0, op_c_i = '0;
  logic [63:0] instr_i = '0;
  logic        carry_i = 1'b0;
  logic [31:0] result_o;
  logic [7:0]  dest_o;
  logic        valid_o, zero_o, sign_o, carry_o, ovf_o, flag_we_o, err_o;

  int checks = 0;
  int errors = 0;

  logic [31:0] m_res = '0;
  logic [7:0]  m_dest = '0;
  logic [3:0]  m_flags = '0; // {z,s,c,o}

  tri_add_unit uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
    .op_a_i(op_a_i), .op_b_i(op_b_i), .op_c_i(op_c_i),
    .instr_i(instr_i), .carry_i(carry_i),
    .result_o(result_o), .dest_o(dest_o), .valid_o(valid_o),
    .zero_o(zero_o), .sign_o(sign_o), .carry_o(carry_o), .ovf_o(ovf_o),
    .flag_we_o(flag_we_o), .err_o(err_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic chk(input string req, input string what, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  function automatic logic [63:0] mk(input int ha, input int hb, input int hc,
                                     input logic [2:0] neg_abc, input logic x,
                                     input logic cc, input int sh, input logic [7:0] d);
    logic [63:0] w = '0;
    w[36:35] = 2'(ha); w[34:33] = 2'(hb); w[32:31] = 2'(hc);
    w[51] = neg_abc[2]; w[50] = neg_abc[1]; w[49] = neg_abc[0];
    w[48] = x; w[47] = cc; w[38:37] = 2'(sh); w[7:0] = d;
    return w;
  endfunction

  function automatic logic [31:0] pick(input logic [31:0] v, input logic [1:0] h, input logic n);
    logic [31:0] r;
    r = (h == 2'd1) ? (v & 32'h0000_FFFF) : (h == 2'd2) ? (v >> 16) : v;
    return n ? (32'd0 - r) : r;
  endfunction

  task automatic run_op(input string req, input logic [31:0] a, input logic [31:0] b,
                        input logic [31:0] c, input logic [63:0] w, input logic cin);
    logic [31:0] pa, pb, pc, l1, l2, fin;
    logic [63:0] s1, s2;
    longint      ss;
    logic        bad, xb, ccb;
    logic [1:0]  sh;
    xb = w[48]; ccb = w[47]; sh = w[38:37];
    bad = (sh == 2'd3) || (w[36:35] == 2'd3) || (w[34:33] == 2'd3) || (w[32:31] == 2'd3)
        || (xb && sh == 2'd1) || (xb && ccb);
    pa = pick(a, w[36:35], w[51]);
    pb = pick(b, w[34:33], w[50]);
    pc = pick(c, w[32:31], w[49]);
    s1 = 64'(pa) + 64'(pb) + 64'(xb & cin);
    l1 = s1[31:0];
    l2 = (sh == 2'd1) ? 32'(s1[32:0] >> 16) : (sh == 2'd2) ? (l1 << 16) : l1;
    s2 = 64'(l2) + 64'(pc);
    fin = s2[31:0];
    ss = longint'($signed(l2)) + longint'($signed(pc));

    @(negedge clk_i);
    op_a_i = a; op_b_i = b; op_c_i = c; instr_i = w; carry_i = cin; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    if (bad) begin
      chk(req, "err_o (R9)", err_o, 1);
      chk(req, "valid_o on error (R9)", valid_o, 0);
      chk(req, "flag_we_o on error (R9)", flag_we_o, 0);
      chk(req, "result hold on error (R9)", result_o, m_res);
    end else begin
      m_res = fin; m_dest = w[7:0];
      if (ccb) m_flags = {fin == 0, fin[31], s2[32],
                          (ss > 64'sd2147483647 || ss < -64'sd2147483648) || (l1 < pa)};
      chk(req, "valid_o (R4)", valid_o, 1);
      chk(req, "err_o", err_o, 0);
      chk(req, "result", result_o, fin);
      chk(req, "dest (R4)", dest_o, w[7:0]);
      chk(req, "flag_we_o (R7)", flag_we_o, ccb);
    end
    chk(req, "flags (R7/R8)", {zero_o, sign_o, carry_o, ovf_o}, m_flags);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    #(CLK_PERIOD * 3);
    // R1 reset state
    chk("R1", "outputs in reset",
        {result_o, dest_o, valid_o, zero_o, sign_o, carry_o, ovf_o, flag_we_o, err_o}, '0);
    @(negedge clk_i); rst_ni = 1'b1;

    // R6: first sum carries out, right shift keeps it
    run_op("R6", 32'hFFFF_0000, 32'h0001_0000, 32'd5, mk(0,0,0,3'b000,0,1,1,8'd3), 0);
    chk("R6", "33-bit right shift", result_o, 32'h0001_0005);
    // R5: left shift
    run_op("R5", 32'h0000_1234, 32'd0, 32'd0, mk(0,0,0,3'b000,0,0,2,8'd9), 0);
    chk("R5", "left shift", result_o, 32'h1234_0000);
    // R2: high half of A, low half of B
    run_op("R2", 32'hABCD_1234, 32'h5555_0001, 32'd0, mk(2,1,0,3'b000,0,0,0,8'd1), 0);
    chk("R2", "half select", result_o, 32'h0000_ABCE);
    // R3: negate A after half select
    run_op("R3", 32'h0001_FFFF, 32'd0, 32'd0, mk(2,0,0,3'b100,0,0,0,8'd2), 0);
    chk("R3", "negate A", result_o, 32'hFFFF_FFFF);
    // R4: carry in used only with extended bit
    run_op("R4", 32'd1, 32'd1, 32'd1, mk(0,0,0,3'b000,1,0,0,8'd4), 1);
    chk("R4", "carry in set", result_o, 32'd4);
    run_op("R4", 32'd1, 32'd1, 32'd1, mk(0,0,0,3'b000,1,0,0,8'd4), 0);
    chk("R4", "carry in clear", result_o, 32'd3);
    run_op("R4", 32'd1, 32'd1, 32'd1, mk(0,0,0,3'b000,0,0,0,8'd4), 1);
    chk("R4", "carry ignored without ext", result_o, 32'd3);
    // R8: first-stage wrap
    run_op("R8", 32'hFFFF_FFFF, 32'd1, 32'd0, mk(0,0,0,3'b000,0,1,0,8'd5), 0);
    chk("R8", "wrap flags z,s,c,o", {zero_o, sign_o, carry_o, ovf_o}, 4'b1001);
    // R8: signed overflow in final add
    run_op("R8", 32'h7FFF_FFFF, 32'd0, 32'd1, mk(0,0,0,3'b000,0,1,0,8'd6), 0);
    chk("R8", "signed overflow flags", {zero_o, sign_o, carry_o, ovf_o}, 4'b0101);
    // R7: no flag write holds flags
    run_op("R7", 32'd0, 32'd0, 32'd0, mk(0,0,0,3'b000,0,0,0,8'd7), 0);
    chk("R7", "flags held", {zero_o, sign_o, carry_o, ovf_o}, 4'b0101);
    // R9: unsupported combinations
    run_op("R9", 32'd1, 32'd2, 32'd3, mk(0,0,0,3'b000,1,1,0,8'd8), 1);
    run_op("R9", 32'd1, 32'd2, 32'd3, mk(0,0,0,3'b000,1,0,1,8'd8), 1);
    run_op("R9", 32'd1, 32'd2, 32'd3, mk(3,0,0,3'b000,0,0,0,8'd8), 0);
    run_op("R9", 32'd1, 32'd2, 32'd3, mk(0,0,0,3'b000,0,0,3,8'd8), 0);
    chk("R9", "dest unchanged after error", dest_o, 8'd7);
    // R10: idle cycle
    @(negedge clk_i);
    chk("R10", "idle strobes", {valid_o, flag_we_o, err_o}, 3'b000);
    chk("R10", "idle hold", {result_o, dest_o}, {m_res, m_dest});

    // random mix
    for (int n = 0; n < 400; n++) begin
      logic [63:0] w;
      int ha, hb, hc, sh;
      logic x, cc;
      ha = ($urandom_range(0,15) == 0) ? 3 : $urandom_range(0,2);
      hb = ($urandom_range(0,15) == 0) ? 3 : $urandom_range(0,2);
      hc = ($urandom_range(0,15) == 0) ? 3 : $urandom_range(0,2);
      sh = ($urandom_range(0,15) == 0) ? 3 : $urandom_range(0,2);
      x  = 1'($urandom_range(0,1));
      cc = 1'($urandom_range(0,1));
      if (x && $urandom_range(0,7) != 0) begin
        cc = 1'b0;
        if (sh == 1) sh = 0;
      end
      w = {$urandom, $urandom};
      w[51:47] = {3'($urandom_range(0,7)), x, cc};
      w[38:37] = 2'(sh); w[36:35] = 2'(ha); w[34:33] = 2'(hb); w[32:31] = 2'(hc);
      run_op("R2/R3/R4/R5/R6/R7/R8", $urandom, $urandom, $urandom, w, 1'($urandom_range(0,1)));
      if ($urandom_range(0,3) == 0) begin
        @(negedge clk_i);
        chk("R10", "random idle strobes", {valid_o, flag_we_o, err_o}, 3'b000);
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule